// File: doc/BRIEF.md
# Raster Pixel-List Overlay Plotter

This block paints a sparse set of pixels on top of a live 640x480 raster scan without a frame buffer. An external timing generator supplies the current column, the current row, a display-active flag and a vertical-blank flag. The pixels to paint are held as an ordered list in two external coordinate memories, one for X and one for Y, addressed by a single shared index. The block walks that index forward in step with the raster. Whenever the scan position equals both coordinates of the current entry, it outputs the line colour and moves on to the next entry. Otherwise it outputs a background pixel supplied alongside the raster. Outside the active area it outputs a blue border, and during vertical blank it outputs black.

The list must be sorted in raster order: by row first, then by column. The block drives the read address one cycle ahead, so the synchronous memories always present the entry that the compare needs. The list length and the line colour are sampled once per frame, on the cycle vertical blank begins.

Top module: `pixlist_overlay`

## Requirements
- R1: While reset is asserted and after its release, pix_o is 16'h0000, blank_o is 1 and rd_addr_o is 0 until inputs change them.
- R2: One cycle after a cycle with vblank_i high, pix_o is black (16'h0000) and blank_o is 1; otherwise blank_o is 0.
- R3: One cycle after a cycle with vblank_i low and active_i low, pix_o is the border colour 16'h001F. RGB565 packs red in bits [15:11], green in bits [10:5] and blue in bits [4:0].
- R4: One cycle after an active cycle with no list match, pix_o equals the bg_pix_i value of that cycle.
- R5: An active cycle draws the latched line colour on pix_o one cycle later only when col_i equals the entry's X and row_i equals the entry's Y. A match on the column alone or on the row alone gives the background.
- R6: Each drawn pixel advances the list index by one. Entries on adjacent columns are all drawn with no missed cycle, because the next entry is fetched in advance.
- R7: The index returns to 0 on the cycle vblank_i rises, so the whole list is drawn again in every frame. During vertical blank, rd_addr_o is 0.
- R8: list_len_i is sampled when vblank_i rises, and values above the list depth are clamped to the depth. Entries at or beyond the sampled length are never drawn.
- R9: line_color_i is sampled when vblank_i rises. A change to it within a frame does not alter that frame's drawn pixels.
- R10: An entry equal to the last drawn coordinate is skipped in one cycle without drawing, and the walk continues. A following distinct entry at least two columns further on is drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_i | input | 10 | Current raster column |
| row_i | input | 10 | Current raster row |
| active_i | input | 1 | High inside the visible area |
| vblank_i | input | 1 | High during vertical blank |
| line_color_i | input | 16 | RGB565 colour for list pixels, sampled at frame start |
| bg_pix_i | input | 16 | RGB565 background pixel for the current position |
| list_len_i | input | 10 | Number of valid list entries, sampled at frame start |
| rd_addr_o | output | 10 | Read address for both coordinate memories |
| rd_x_i | input | 10 | X coordinate read back, one cycle after the address |
| rd_y_i | input | 10 | Y coordinate read back, one cycle after the address |
| pix_o | output | 16 | RGB565 output pixel, one cycle behind the raster inputs |
| blank_o | output | 1 | High while the output is in vertical blank |

## Verification
A wrong index shows up at the ports within the same frame. If the index stalls or jumps, every later entry in the list is missing from pix_o. If the index fails to reset at vertical blank, the next frame draws nothing, and rd_addr_o is non-zero during blank. If the prefetch is off by one cycle, the second of two horizontally adjacent pixels disappears on the very next cycle. If the colour or length register is wrong, the first drawn pixel of the frame shows the wrong colour, or entries past the end of the list appear.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int COORD_W = 10;
  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [15:0] rgb565_t;

  function automatic rgb565_t pack565(input logic [4:0] r, input logic [5:0] g, input logic [4:0] b);
    return {r, g, b};
  endfunction

  function automatic rgb565_t border_color();
    return pack565(5'd0, 6'd0, 5'h1F);
  endfunction

  function automatic rgb565_t black_color();
    return pack565(5'd0, 6'd0, 5'd0);
  endfunction

  function automatic logic coord_match(input coord_t ax, input coord_t ay,
                                       input coord_t bx, input coord_t by);
    return (ax == bx) && (ay == by);
  endfunction
endpackage

// File: rtl/ovl_frame_ctl.sv
module ovl_frame_ctl #(
  parameter int LIST_DEPTH = 800,
  localparam int IW = $clog2(LIST_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vblank,
  input  logic [IW-1:0]       list_len,
  input  ovl_pkg::rgb565_t    line_color,
  output logic                frame_start,
  output logic [IW-1:0]       len_q,
  output ovl_pkg::rgb565_t    color_q
);
  logic vblank_q;

  assign frame_start = vblank && !vblank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank_q <= 1'b0;
      len_q    <= '0;
      color_q  <= '0;
    end else begin
      vblank_q <= vblank;
      if (frame_start) begin
        color_q <= line_color;
        len_q   <= (list_len > IW'(LIST_DEPTH)) ? IW'(LIST_DEPTH) : list_len;
      end
    end
  end
endmodule

// File: rtl/ovl_list_walker.sv
module ovl_list_walker #(
  parameter int LIST_DEPTH = 800,
  localparam int IW = $clog2(LIST_DEPTH + 1),
  localparam int AW = $clog2(LIST_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             vblank,
  input  logic             active,
  input  ovl_pkg::coord_t  col,
  input  ovl_pkg::coord_t  row,
  input  ovl_pkg::coord_t  rd_x,
  input  ovl_pkg::coord_t  rd_y,
  input  logic [IW-1:0]    len_q,
  output logic [AW-1:0]    rd_addr,
  output logic [IW-1:0]    idx,
  output logic             hit,
  output logic             dup
);
  import ovl_pkg::*;

  logic [IW-1:0] idx_q, idx_n;
  coord_t        prev_x, prev_y;
  logic          prev_ok;
  logic          in_range;

  assign in_range = idx_q < len_q;
  assign dup = !frame_start && in_range && prev_ok && coord_match(rd_x, rd_y, prev_x, prev_y);
  assign hit = !frame_start && !vblank && active && in_range && !dup
               && coord_match(col, row, rd_x, rd_y);

  always_comb begin
    if (frame_start)      idx_n = '0;
    else if (hit || dup)  idx_n = idx_q + IW'(1);
    else                  idx_n = idx_q;
  end

  // Address leads the index register by one cycle: memory data lines up with idx_q.
  assign rd_addr = AW'(idx_n);
  assign idx     = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      prev_x  <= '0;
      prev_y  <= '0;
      prev_ok <= 1'b0;
    end else begin
      idx_q <= idx_n;
      if (frame_start) begin
        prev_ok <= 1'b0;
      end else if (hit) begin
        prev_x  <= rd_x;
        prev_y  <= rd_y;
        prev_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_color_mux.sv
module ovl_color_mux (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank,
  input  logic              active,
  input  logic              hit,
  input  ovl_pkg::rgb565_t  color_q,
  input  ovl_pkg::rgb565_t  bg_pix,
  output ovl_pkg::rgb565_t  pix,
  output logic              blank
);
  import ovl_pkg::*;

  rgb565_t pix_n;

  always_comb begin
    if (vblank)       pix_n = black_color();
    else if (!active) pix_n = border_color();
    else if (hit)     pix_n = color_q;
    else              pix_n = bg_pix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix   <= '0;
      blank <= 1'b1;
    end else begin
      pix   <= pix_n;
      blank <= vblank;
    end
  end
endmodule

// File: rtl/pixlist_overlay.sv
module pixlist_overlay #(
  parameter int LIST_DEPTH = 800,
  localparam int IW = $clog2(LIST_DEPTH + 1),
  localparam int AW = $clog2(LIST_DEPTH),
  localparam int CW = ovl_pkg::COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] col_i,
  input  logic [CW-1:0] row_i,
  input  logic          active_i,
  input  logic          vblank_i,
  input  logic [15:0]   line_color_i,
  input  logic [15:0]   bg_pix_i,
  input  logic [IW-1:0] list_len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [CW-1:0] rd_x_i,
  input  logic [CW-1:0] rd_y_i,
  output logic [15:0]   pix_o,
  output logic          blank_o
);
  logic          frame_start;
  logic [IW-1:0] len_q;
  logic [15:0]   color_q;
  logic [IW-1:0] idx;
  logic          hit;
  logic          dup;

  ovl_frame_ctl #(.LIST_DEPTH(LIST_DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .vblank(vblank_i), .list_len(list_len_i),
    .line_color(line_color_i), .frame_start(frame_start), .len_q(len_q), .color_q(color_q)
  );

  ovl_list_walker #(.LIST_DEPTH(LIST_DEPTH)) u_walk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vblank(vblank_i),
    .active(active_i), .col(col_i), .row(row_i), .rd_x(rd_x_i), .rd_y(rd_y_i),
    .len_q(len_q), .rd_addr(rd_addr_o), .idx(idx), .hit(hit), .dup(dup)
  );

  ovl_color_mux u_mux (
    .clk(clk), .rst_n(rst_n), .vblank(vblank_i), .active(active_i), .hit(hit),
    .color_q(color_q), .bg_pix(bg_pix_i), .pix(pix_o), .blank(blank_o)
  );
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int IW = 10,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vblank,
  input logic          active,
  input logic [CW-1:0] col,
  input logic [CW-1:0] row,
  input logic [CW-1:0] rd_x,
  input logic [CW-1:0] rd_y,
  input logic [15:0]   pix,
  input logic          blank,
  input logic [IW-1:0] idx,
  input logic [IW-1:0] len_q,
  input logic [15:0]   color_q,
  input logic          frame_start,
  input logic          hit,
  input logic          dup
);
  AST_VBLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (pix == 16'h0000) && blank); // R2
  AST_BORDER_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank && !active) |=> (pix == 16'h001F) && !blank); // R3
  AST_HIT_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pix == $past(color_q)); // R5
  AST_HIT_BOTH_AXES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> active && (col == rd_x) && (row == rd_y)); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && (hit || dup)) |=> idx == $past(idx) + IW'(1)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !hit && !dup) |=> $stable(idx)); // R6
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> idx == '0); // R7
  AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len_q); // R8
  AST_COLOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(color_q)); // R9
  AST_DUP_NO_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && dup)); // R10
endmodule

bind pixlist_overlay ovl_checker #(.IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank_i), .active(active_i),
  .col(col_i), .row(row_i), .rd_x(rd_x_i), .rd_y(rd_y_i),
  .pix(pix_o), .blank(blank_o), .idx(idx), .len_q(len_q), .color_q(color_q),
  .frame_start(frame_start), .hit(hit), .dup(dup)
);

// File: tb/pixlist_overlay_tb_top.sv
module pixlist_overlay_tb_top;
  localparam int DEPTH = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  col_i = '0, row_i = '0;
  logic        active_i = 1'b0, vblank_i = 1'b0;
  logic [15:0] line_color_i = '0, bg_pix_i = '0;
  logic [9:0]  list_len_i = '0;
  logic [9:0]  rd_addr_o;
  logic [9:0]  rd_x_i = '0, rd_y_i = '0;
  logic [15:0] pix_o;
  logic        blank_o;

  logic [9:0] mem_x [DEPTH];
  logic [9:0] mem_y [DEPTH];

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] ref_color;
  int          ref_len;

  logic [15:0] q_pix [$];
  logic        q_blk [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  pixlist_overlay dut_i (.*);

  // Synchronous coordinate memories, one cycle read latency
  always_ff @(posedge clk) begin
    rd_x_i <= (rd_addr_o < 10'(DEPTH)) ? mem_x[rd_addr_o] : '0;
    rd_y_i <= (rd_addr_o < 10'(DEPTH)) ? mem_y[rd_addr_o] : '0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic listed(input logic [9:0] c, input logic [9:0] r);
    for (int k = 0; k < ref_len; k++)
      if (mem_x[k] == c && mem_y[k] == r) return 1'b1;
    return 1'b0;
  endfunction

  // Driver: one raster cycle, expected result pushed to the scoreboard
  task automatic drive(input string tag, input logic vb, input logic act,
                       input logic [9:0] c, input logic [9:0] r);
    logic [15:0] bg, e;
    @(negedge clk);
    bg = {c[4:0], r[5:0], 5'b01010};
    vblank_i = vb; active_i = act; col_i = c; row_i = r; bg_pix_i = bg;
    if (vb)        e = 16'h0000;
    else if (!act) e = 16'h001F;
    else if (listed(c, r)) e = ref_color;
    else           e = bg;
    q_pix.push_back(e);
    q_blk.push_back(vb);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares each registered output one edge after its inputs
  always @(posedge clk) begin
    #1;
    if (q_pix.size() > 0) begin
      string t;
      logic [15:0] ep;
      logic eb;
      t  = q_tag.pop_front();
      ep = q_pix.pop_front();
      eb = q_blk.pop_front();
      check({t, " pixel"}, 32'(pix_o), 32'(ep));
      check({t, " blank"}, 32'(blank_o), 32'(eb));
    end
  end

  task automatic run_row(input string tag, input logic [9:0] r, input int c0, input int c1);
    for (int c = c0; c <= c1; c++) drive(tag, 1'b0, 1'b1, 10'(c), r);
    for (int k = 0; k < 2; k++) drive(tag, 1'b0, 1'b0, 10'd0, r);
  endtask

  task automatic run_frame(input string tag, input logic [15:0] color, input int len,
                           input logic mid_change);
    @(negedge clk);
    line_color_i = color;
    list_len_i   = 10'(len);
    ref_color    = color;
    ref_len      = (len > DEPTH) ? DEPTH : len;
    for (int k = 0; k < 4; k++) drive({tag, " R2"}, 1'b1, 1'b0, 10'd0, 10'd0);
    #1;
    check("R7 address at blank", 32'(rd_addr_o), 32'd0);
    if (mid_change) line_color_i = ~color;   // R9: change after sampling
    run_row(tag, 10'd0, 0, 11);
    run_row(tag, 10'd1, 0, 11);
    run_row(tag, 10'd2, 0, 11);
    run_row(tag, 10'd479, 632, 639);
    drive({tag, " R3"}, 1'b0, 1'b0, 10'd0, 10'd0);
    wait (q_pix.size() == 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin mem_x[k] = 10'd1023; mem_y[k] = 10'd1023; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pix", 32'(pix_o), 32'h0);
    check("R1 reset blank", 32'(blank_o), 32'h1);
    check("R1 reset addr", 32'(rd_addr_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release addr", 32'(rd_addr_o), 32'h0);

    // Corners, single-axis misses, adjacent pixels (R4 R5 R6)
    mem_x[0] = 10'd0;   mem_y[0] = 10'd0;
    mem_x[1] = 10'd5;   mem_y[1] = 10'd1;
    mem_x[2] = 10'd6;   mem_y[2] = 10'd1;
    mem_x[3] = 10'd7;   mem_y[3] = 10'd1;
    mem_x[4] = 10'd639; mem_y[4] = 10'd479;
    run_frame("R4 R5 R6 frame1", 16'h07E0, 5, 1'b0);
    run_frame("R7 redraw", 16'hF800, 5, 1'b0);
    run_frame("R8 short length", 16'hFFE0, 3, 1'b0);
    run_frame("R9 colour held", 16'h07FF, 5, 1'b1);
    run_frame("R8 clamp", 16'hF81F, 1000, 1'b0);

    // Duplicate skipping (R10)
    mem_x[0] = 10'd2;  mem_y[0] = 10'd0;
    mem_x[1] = 10'd2;  mem_y[1] = 10'd0;
    mem_x[2] = 10'd6;  mem_y[2] = 10'd0;
    mem_x[3] = 10'd6;  mem_y[3] = 10'd0;
    mem_x[4] = 10'd9;  mem_y[4] = 10'd2;
    mem_x[5] = 10'd11; mem_y[5] = 10'd2;
    run_frame("R10 duplicates", 16'h07E0, 6, 1'b0);
    finish_run();
  end
endmodule